// File: doc/BRIEF.md
# Dual-Bank Configurable Interrupt Controller

This block gathers 64 interrupt inputs and reduces them to two processor request lines, a normal request (`irq_o`) and a fast request (`fiq_o`). The inputs form two banks of 32. The low bank holds sources 0 to 31 and the high bank holds sources 32 to 63. Each bank has two independent register groups, one that feeds the normal request and one that feeds the fast request. Every group keeps its own enable mask, sensing mode, polarity and pending state. Each input is brought into the clock domain through a two-flop synchronizer. It can then be sensed as a level or as an edge, either active-high or active-low.

Software reaches the block through a plain 32-bit register port with word addresses and a read latency of one cycle. An edge event is latched until software writes a one to its bit in the group's clear word. A level source simply follows its input. The status word of a group shows the sources that are both pending and enabled. The OR of all status bits in the normal groups drives `irq_o`, and the OR of all status bits in the fast groups drives `fiq_o`. Both request lines are registered.

Top module: `intc_dual_bank`

## Requirements
- R1: After reset every enable, mode and polarity word reads 0, and `irq_o` and `fiq_o` are low.
- R2: Word offset 0 of a group (the raw word) returns the synchronized input levels of its bank, with bit n giving source n of that bank. The value is taken before polarity and masking are applied.
- R3: A source in level mode (mode bit 0) with polarity bit 0 is pending while its input is high and not pending once it is low. A write of one to its clear bit (group offset 2) has no lasting effect while the input stays high.
- R4: A source in level mode with polarity bit 1 (group offset 4) is pending while its input is low.
- R5: A source in edge mode (mode bit 1, group offset 3) with polarity 0 latches a rising edge. The latch holds after the input falls, and writing 0 to the clear word leaves it set. Writing 1 to the clear bit clears it.
- R6: A source in edge mode with polarity 1 latches only a falling edge. A change of polarity alone does not latch an event.
- R7: The status word (group offset 5) shows only sources that are both pending and enabled (enable word, group offset 1). A latched edge on a masked source appears, and raises the request, as soon as the source is enabled.
- R8: `irq_o` is the OR of the status bits of both normal groups, and `fiq_o` is the OR of the status bits of both fast groups. The normal and fast groups do not affect each other.
- R9: The word addresses of the groups are: normal low 0, fast low 8, normal high 24, fast high 32. These equal byte offsets 0x00, 0x20, 0x60 and 0x80. Within a group the word order is raw, enable, clear, mode, polarity, status, followed by two reserved words.
- R10: Word 20 reads the revision constant 0x00010000 and word 21 reads the feature constant 0x00000040. All other words read 0, and so does the clear word. Writes to read-only and reserved words are ignored.
- R11: A change on an input reaches `irq_o`/`fiq_o` on the fourth rising clock edge after it: two synchronizer stages, the pending flop, then the output flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| src_i | input | 64 | Asynchronous interrupt inputs, bit n is source n |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 6 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after `rd_en_i` |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
The bench asserts a level source and writes its clear bit while the input is still high. A design that latched level sources would then keep the request asserted after the input dropped. It latches a rising edge on a source that is still masked and checks that the request rises only after the enable is set. A design that stored masked pending bits wrongly would lose that interrupt. It changes only the polarity of an idle edge-mode source. A design that compared the new polarity against the old sample would raise a spurious event. It also drives the high bank's fast group alone. A design that crossed the banks or the normal and fast groups would assert the wrong request line or report status at the wrong address.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int GRP_N     = 4;   // bank*2 + kind, kind 0 = normal, 1 = fast
    localparam int GRP_WORDS = 8;
    localparam int HI_BASE   = 24;  // first word of the high bank groups
    localparam int WORD_REV  = 20;
    localparam int WORD_FEAT = 21;

    localparam logic [2:0] OFS_RAW  = 3'd0;
    localparam logic [2:0] OFS_EN   = 3'd1;
    localparam logic [2:0] OFS_CLR  = 3'd2;
    localparam logic [2:0] OFS_MODE = 3'd3;
    localparam logic [2:0] OFS_POL  = 3'd4;
    localparam logic [2:0] OFS_STAT = 3'd5;

    function automatic int grp_base(input int g);
        int bank;
        int kind;
        bank = g / 2;
        kind = g % 2;
        return (bank == 0) ? kind * GRP_WORDS : HI_BASE + kind * GRP_WORDS;
    endfunction

    function automatic int grp_bank(input int g);
        return g / 2;
    endfunction

    function automatic bit grp_is_fast(input int g);
        return (g % 2) == 1;
    endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int WIDTH = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage1_q <= '0;
            stage2_q <= '0;
            prev_q   <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
            prev_q   <= stage2_q;
        end
    end

    assign sync_o = stage2_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/intc_group.sv
module intc_group #(
    parameter int WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] sync_i,
    input  logic [WIDTH-1:0] prev_i,
    input  logic             en_we_i,
    input  logic             mode_we_i,
    input  logic             pol_we_i,
    input  logic             clr_we_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] en_o,
    output logic [WIDTH-1:0] mode_o,
    output logic [WIDTH-1:0] pol_o,
    output logic [WIDTH-1:0] status_o
);
    logic [WIDTH-1:0] en_q;
    logic [WIDTH-1:0] mode_q;
    logic [WIDTH-1:0] pol_q;
    logic [WIDTH-1:0] pend_q;
    logic [WIDTH-1:0] pend_d;
    logic [WIDTH-1:0] act_now;
    logic [WIDTH-1:0] act_old;
    logic [WIDTH-1:0] hit_v;
    logic [WIDTH-1:0] clr_v;
    logic [WIDTH-1:0] keep_v;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q   <= '0;
            mode_q <= '0;
            pol_q  <= '0;
        end else begin
            if (en_we_i)   en_q   <= wdata_i;
            if (mode_we_i) mode_q <= wdata_i;
            if (pol_we_i)  pol_q  <= wdata_i;
        end
    end

    // polarity is applied to both samples, so a polarity change alone makes no edge
    always_comb begin
        act_now = sync_i ^ pol_q;
        act_old = prev_i ^ pol_q;
        hit_v   = act_now & ~act_old;
        clr_v   = clr_we_i ? wdata_i : '0;
        keep_v  = pend_q & mode_q & ~clr_v;
        // edge: a new event wins over a clear in the same cycle
        pend_d  = (mode_q & (hit_v | (pend_q & ~clr_v))) | (~mode_q & act_now);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q <= '0;
        else         pend_q <= pend_d;
    end

    assign en_o     = en_q;
    assign mode_o   = mode_q;
    assign pol_o    = pol_q;
    assign status_o = pend_q & en_q;

    AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mode_we_i |=> ((pend_q & $past(keep_v)) == $past(keep_v))); // R5

    AST_EDGE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_we_i && !mode_we_i) |=> ((pend_q & $past(clr_v & mode_q & ~hit_v)) == '0)); // R5
endmodule

// File: rtl/intc_dual_bank.sv
module intc_dual_bank #(
    parameter int          BANK_W  = 32,
    parameter int          ADDR_W  = 6,
    parameter logic [31:0] REV_ID  = 32'h0001_0000,
    parameter logic [31:0] FEAT_ID = 32'h0000_0040
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [2*BANK_W-1:0] src_i,
    input  logic                wr_en_i,
    input  logic                rd_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [BANK_W-1:0]   wdata_i,
    output logic [BANK_W-1:0]   rdata_o,
    output logic                irq_o,
    output logic                fiq_o
);
    import intc_pkg::*;

    localparam int SRC_N = 2 * BANK_W;
    localparam logic [ADDR_W-1:0] A_REV  = ADDR_W'(WORD_REV);
    localparam logic [ADDR_W-1:0] A_FEAT = ADDR_W'(WORD_FEAT);

    logic [SRC_N-1:0]  sync_v;
    logic [SRC_N-1:0]  prev_v;
    logic [BANK_W-1:0] g_raw  [GRP_N];
    logic [BANK_W-1:0] g_en   [GRP_N];
    logic [BANK_W-1:0] g_mode [GRP_N];
    logic [BANK_W-1:0] g_pol  [GRP_N];
    logic [BANK_W-1:0] g_stat [GRP_N];
    logic [GRP_N-1:0]  g_sel;
    logic [2:0]        ofs;
    logic [BANK_W-1:0] rd_val;
    logic              rd_known;
    logic              irq_any;
    logic              fiq_any;
    logic              irq_en_any;
    logic              fiq_en_any;

    assign ofs = addr_i[2:0];

    intc_sync #(.WIDTH(SRC_N)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (src_i),
        .sync_o (sync_v),
        .prev_o (prev_v)
    );

    for (genvar g = 0; g < GRP_N; g++) begin : gen_grp
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(grp_base(g));
        localparam int LSB = grp_bank(g) * BANK_W;

        assign g_sel[g] = (addr_i[ADDR_W-1:3] == BASE[ADDR_W-1:3]);
        assign g_raw[g] = sync_v[LSB +: BANK_W];

        intc_group #(.WIDTH(BANK_W)) i_group (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .sync_i    (sync_v[LSB +: BANK_W]),
            .prev_i    (prev_v[LSB +: BANK_W]),
            .en_we_i   (wr_en_i && g_sel[g] && ofs == OFS_EN),
            .mode_we_i (wr_en_i && g_sel[g] && ofs == OFS_MODE),
            .pol_we_i  (wr_en_i && g_sel[g] && ofs == OFS_POL),
            .clr_we_i  (wr_en_i && g_sel[g] && ofs == OFS_CLR),
            .wdata_i   (wdata_i),
            .en_o      (g_en[g]),
            .mode_o    (g_mode[g]),
            .pol_o     (g_pol[g]),
            .status_o  (g_stat[g])
        );
    end

    always_comb begin
        rd_val   = '0;
        rd_known = 1'b0;
        if (addr_i == A_REV) begin
            rd_val   = REV_ID;
            rd_known = 1'b1;
        end else if (addr_i == A_FEAT) begin
            rd_val   = FEAT_ID;
            rd_known = 1'b1;
        end
        for (int g = 0; g < GRP_N; g++) begin
            if (g_sel[g]) begin
                case (ofs)
                    OFS_RAW:  begin rd_val = g_raw[g];  rd_known = 1'b1; end
                    OFS_EN:   begin rd_val = g_en[g];   rd_known = 1'b1; end
                    OFS_CLR:  begin rd_val = '0;        rd_known = 1'b1; end
                    OFS_MODE: begin rd_val = g_mode[g]; rd_known = 1'b1; end
                    OFS_POL:  begin rd_val = g_pol[g];  rd_known = 1'b1; end
                    OFS_STAT: begin rd_val = g_stat[g]; rd_known = 1'b1; end
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        irq_any    = 1'b0;
        fiq_any    = 1'b0;
        irq_en_any = 1'b0;
        fiq_en_any = 1'b0;
        for (int g = 0; g < GRP_N; g++) begin
            if (grp_is_fast(g)) begin
                fiq_any    = fiq_any | (|g_stat[g]);
                fiq_en_any = fiq_en_any | (|g_en[g]);
            end else begin
                irq_any    = irq_any | (|g_stat[g]);
                irq_en_any = irq_en_any | (|g_en[g]);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_o <= '0;
            irq_o   <= 1'b0;
            fiq_o   <= 1'b0;
        end else begin
            if (rd_en_i) rdata_o <= rd_val;
            irq_o <= irq_any;
            fiq_o <= fiq_any;
        end
    end

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(irq_en_any)); // R7

    AST_FIQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fiq_o) |-> $past(fiq_en_any)); // R8

    AST_RSVD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && !rd_known) |=> (rdata_o == '0)); // R10
endmodule

// File: tb/test_intc_dual_bank.sv
module test_intc_dual_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        fiq;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    intc_dual_bank i_intc_dual_bank (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .src_i   (src),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq),
        .fiq_o   (fiq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: queue the expected value, then issue the read
    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // monitor: compare each read result one cycle after its strobe
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdata !== e) begin
                errors++;
                $display("FAIL %s: got %h expected %h", t, rdata, e);
            end
        end
    end

    task automatic chk_out(input logic ei, input logic ef, input string tag);
        checks++;
        if (irq !== ei || fiq !== ef) begin
            errors++;
            $display("FAIL %s: got irq=%b fiq=%b expected irq=%b fiq=%b", tag, irq, fiq, ei, ef);
        end
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        chk_out(1'b0, 1'b0, "R1 outputs after reset");
        rd(6'd1,  32'h0, "R1 enable normal low");
        rd(6'd3,  32'h0, "R1 mode normal low");
        rd(6'd4,  32'h0, "R1 polarity normal low");
        rd(6'd33, 32'h0, "R1 enable fast high");

        // R10 constants, reserved words, ignored writes
        rd(6'd20, 32'h0001_0000, "R10 revision");
        rd(6'd21, 32'h0000_0040, "R10 feature");
        rd(6'd16, 32'h0, "R10 reserved 0x40");
        rd(6'd22, 32'h0, "R10 reserved 0x58");
        rd(6'd6,  32'h0, "R10 reserved group word");
        rd(6'd40, 32'h0, "R10 beyond map");
        wr(6'd20, 32'hFFFF_FFFF);
        wr(6'd16, 32'hFFFF_FFFF);
        wr(6'd5,  32'hFFFF_FFFF);
        rd(6'd20, 32'h0001_0000, "R10 revision after write");
        rd(6'd16, 32'h0, "R10 reserved after write");
        rd(6'd5,  32'h0, "R10 status after write");

        // R2 / R9 raw words and bank placement
        src = 64'h8000_0000_0000_0003;
        tick(3);
        rd(6'd0,  32'h0000_0003, "R2 raw normal low");
        rd(6'd8,  32'h0000_0003, "R9 raw fast low");
        rd(6'd24, 32'h8000_0000, "R9 raw normal high");
        wr(6'd4, 32'h0000_0003);
        rd(6'd0,  32'h0000_0003, "R2 raw ignores polarity");
        wr(6'd4, 32'h0);
        chk_out(1'b0, 1'b0, "R7 nothing enabled");
        src = '0;
        tick(4);

        // R11 / R3 level active-high on source 4
        wr(6'd1, 32'h0000_0010);
        src[4] = 1'b1;
        tick(3);
        chk_out(1'b0, 1'b0, "R11 not yet after three edges");
        tick(1);
        chk_out(1'b1, 1'b0, "R11 asserted on fourth edge");
        rd(6'd5, 32'h0000_0010, "R3 level status");
        wr(6'd2, 32'h0000_0010);
        tick(2);
        rd(6'd5, 32'h0000_0010, "R3 clear has no lasting effect");
        rd(6'd2, 32'h0, "R10 clear word reads zero");
        src[4] = 1'b0;
        tick(4);
        chk_out(1'b0, 1'b0, "R3 level released");
        rd(6'd5, 32'h0, "R3 status released");

        // R4 level active-low on source 4
        wr(6'd4, 32'h0000_0010);
        tick(3);
        chk_out(1'b1, 1'b0, "R4 active-low asserted");
        rd(6'd5, 32'h0000_0010, "R4 status");
        src[4] = 1'b1;
        tick(4);
        chk_out(1'b0, 1'b0, "R4 active-low released");
        wr(6'd1, 32'h0);
        wr(6'd4, 32'h0);
        src[4] = 1'b0;
        tick(4);

        // R5 rising edge on source 34 (high bank bit 2)
        wr(6'd27, 32'h0000_0004);
        wr(6'd25, 32'h0000_0004);
        src[34] = 1'b1;
        tick(4);
        chk_out(1'b1, 1'b0, "R5 rising edge latched");
        src[34] = 1'b0;
        tick(4);
        chk_out(1'b1, 1'b0, "R5 latch holds after input falls");
        rd(6'd29, 32'h0000_0004, "R5 status high bank");
        wr(6'd26, 32'h0);
        tick(2);
        rd(6'd29, 32'h0000_0004, "R5 zero write keeps latch");
        wr(6'd26, 32'h0000_0004);
        tick(2);
        chk_out(1'b0, 1'b0, "R5 cleared");
        rd(6'd29, 32'h0, "R5 status cleared");

        // R6 falling edge on source 34
        wr(6'd28, 32'h0000_0004);
        tick(4);
        chk_out(1'b0, 1'b0, "R6 polarity change alone");
        src[34] = 1'b1;
        tick(4);
        chk_out(1'b0, 1'b0, "R6 rising edge ignored");
        src[34] = 1'b0;
        tick(4);
        chk_out(1'b1, 1'b0, "R6 falling edge latched");
        wr(6'd25, 32'h0);
        wr(6'd26, 32'h0000_0004);
        wr(6'd28, 32'h0);
        wr(6'd27, 32'h0);
        tick(3);
        chk_out(1'b0, 1'b0, "R6 cleanup");

        // R7 / R8 masked edge on source 0 in the fast low group
        wr(6'd11, 32'h0000_0001);
        src[0] = 1'b1;
        tick(4);
        chk_out(1'b0, 1'b0, "R7 masked edge silent");
        rd(6'd13, 32'h0, "R7 masked status");
        wr(6'd9, 32'h0000_0001);
        tick(2);
        chk_out(1'b0, 1'b1, "R8 fast group drives only fiq");
        rd(6'd13, 32'h0000_0001, "R7 latched edge after enable");
        wr(6'd10, 32'h0000_0001);
        tick(2);
        chk_out(1'b0, 1'b0, "R5 fast group cleared");
        wr(6'd9, 32'h0);
        src[0] = 1'b0;
        tick(4);

        // R8 / R9 fast high group on source 63
        wr(6'd33, 32'h8000_0000);
        src[63] = 1'b1;
        tick(4);
        chk_out(1'b0, 1'b1, "R8 fast high drives fiq");
        rd(6'd37, 32'h8000_0000, "R9 fast high status");
        rd(6'd29, 32'h0, "R8 normal high unaffected");
        wr(6'd25, 32'h8000_0000);
        tick(2);
        chk_out(1'b1, 1'b1, "R8 both groups on one source");
        src[63] = 1'b0;
        tick(4);
        chk_out(1'b0, 1'b0, "R8 both released");

        tick(2);
        finish_run();
    end
endmodule